// File: doc/BRIEF.md
# Sector Write-Permission Resolver

This block decides, for every program or erase request, whether the addressed sector of a 39-sector flash array may be altered. It keeps one stored lock bit per sector, written one sector at a time through a small control port. It merges these bits with two level inputs. The first is a hardware guard input. When driven low, it locks the two outermost boot sectors, and a build parameter picks which end of the array they sit at. The second is an accelerate level, modelled as a plain digital input rather than a sensed high voltage. While it is active, every lock is lifted and the command sequencer is told to use the shortened two-write program sequence.

A single-sector request is answered with a grant flag in the same cycle. A whole-array erase request is answered with two complementary masks. One lists the sectors that will be erased. The other lists the sectors skipped because they are locked. How long a lock bit takes to program in silicon is outside this block. The block only stores and applies the bits.

Top module: `sector_guard`

## Requirements
- R1: After reset every stored lock bit equals the INIT_PROT parameter (all clear by default) and bypass_active is low.
- R2: A cycle with lock_we high and lock_sect below 39 writes lock_set into that sector's bit, visible from the next cycle. A lock_sect of 39 or more changes no bit.
- R3: With bypass_active low, a request (req_valid high) to a sector whose lock bit is 1 gives req_grant low. A request to a sector with a clear bit and no guard lock gives req_grant high.
- R4: With guard_n low and bypass_active low, sectors 0 and 1 (BOOT_TOP = 0) or sectors 37 and 38 (BOOT_TOP = 1) are denied whatever their stored bits hold. No other sector is affected by guard_n.
- R5: With guard_n high, the two boot sectors are granted or denied purely by their stored bits.
- R6: bypass_active is the accelerate level registered once. It rises the cycle after accel_lvl goes high and falls the cycle after it goes low.
- R7: While bypass_active is high, every in-range request is granted, even if its lock bit is set or guard_n is low. Stored bits are kept and apply again once it falls.
- R8: With erase_all high, bit i of erase_skip is 1 exactly when sector i is currently denied, and erase_take is its complement. With erase_all low, both masks are all zero.
- R9: A request to a sector index of 39 or more is never granted.
- R10: With req_valid low, req_grant is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_we | input | 1 | Write strobe for one stored lock bit |
| lock_sect | input | 6 | Sector index for the lock write |
| lock_set | input | 1 | Value written: 1 locks, 0 unlocks |
| guard_n | input | 1 | Low locks the two outermost boot sectors |
| accel_lvl | input | 1 | Accelerate level, lifts all locks |
| req_valid | input | 1 | A program/erase request is present |
| req_sect | input | 6 | Sector index of the request |
| erase_all | input | 1 | Whole-array erase request |
| req_grant | output | 1 | Request is allowed |
| bypass_active | output | 1 | Short two-write program sequence in force |
| erase_skip | output | 39 | Sectors left untouched by a whole-array erase |
| erase_take | output | 39 | Sectors erased by a whole-array erase |

## Verification
The hardest state to reach is the overlap of a locked boot sector, a low guard and an active accelerate level. There the grant depends on which of the three wins, and on the single cycle of delay on the accelerate path. The stimulus locks both boot pairs and holds the guard low. It then raises the accelerate level, requests the boot sectors on the edge cycle and after it, and drops the level again. Two instances, one per boot end, run side by side against one bench model. A constrained random phase then mixes lock writes, out-of-range indices and level changes.

// File: rtl/sg_pkg.sv
package sg_pkg;
  // True when idx is one of the two outermost boot sectors.
  function automatic logic in_boot_pair(int idx, int n, logic top);
    return top ? (idx >= n - 2) : (idx < 2);
  endfunction
endpackage

// File: rtl/prot_bank.sv
module prot_bank #(
  parameter int N = 39,
  parameter int W = 6,
  parameter logic [N-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_idx,
  input  logic         wr_val,
  output logic [N-1:0] bits
);
  logic [N-1:0] bits_q, bits_d;
  logic         wr_ok;

  assign wr_ok = wr_en && (int'(wr_idx) < N);

  always_comb begin
    bits_d = bits_q;
    for (int i = 0; i < N; i++) begin
      if (wr_ok && int'(wr_idx) == i) bits_d[i] = wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bits_q <= INIT;
    else if (wr_ok) bits_q <= bits_d;
  end

  assign bits = bits_q;

  AST_BIT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> bits_q[$past(wr_idx)] == $past(wr_val)); // R2
  AST_BAD_IDX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_idx) >= N) |=> $stable(bits_q)); // R2
endmodule

// File: rtl/prot_eval.sv
module prot_eval #(
  parameter int   N = 39,
  parameter logic BOOT_TOP = 1'b0
) (
  input  logic [N-1:0] bits,
  input  logic         guard_n,
  input  logic         acc,
  output logic [N-1:0] deny
);
  for (genvar i = 0; i < N; i++) begin : g_sect
    localparam logic PAIR = sg_pkg::in_boot_pair(i, N, BOOT_TOP);
    if (PAIR) begin : g_boot
      assign deny[i] = !acc && (bits[i] || !guard_n);
    end else begin : g_plain
      assign deny[i] = !acc && bits[i];
    end
  end
endmodule

// File: rtl/req_select.sv
module req_select #(
  parameter int N = 39,
  parameter int W = 6
) (
  input  logic [N-1:0] deny,
  input  logic         valid,
  input  logic [W-1:0] sect,
  output logic         grant
);
  logic hit_ok;

  always_comb begin
    hit_ok = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (int'(sect) == i) hit_ok = !deny[i];
    end
  end

  assign grant = valid && hit_ok;
endmodule

// File: rtl/sector_guard.sv
module sector_guard #(
  parameter int   NUM_SECT = 39,
  parameter logic BOOT_TOP = 1'b0,
  parameter logic [NUM_SECT-1:0] INIT_PROT = '0,
  localparam int  SW = $clog2(NUM_SECT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lock_we,
  input  logic [SW-1:0]       lock_sect,
  input  logic                lock_set,
  input  logic                guard_n,
  input  logic                accel_lvl,
  input  logic                req_valid,
  input  logic [SW-1:0]       req_sect,
  input  logic                erase_all,
  output logic                req_grant,
  output logic                bypass_active,
  output logic [NUM_SECT-1:0] erase_skip,
  output logic [NUM_SECT-1:0] erase_take
);
  localparam int BOOT_LO = BOOT_TOP ? NUM_SECT - 2 : 0;
  localparam int BOOT_HI = BOOT_LO + 1;

  logic [NUM_SECT-1:0] lock_bits, deny;
  logic                acc_q, acc_d;

  // Accelerate level, registered once.
  assign acc_d = accel_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= 1'b0;
    else        acc_q <= acc_d;
  end

  prot_bank #(.N(NUM_SECT), .W(SW), .INIT(INIT_PROT)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (lock_we),
    .wr_idx (lock_sect),
    .wr_val (lock_set),
    .bits   (lock_bits)
  );

  prot_eval #(.N(NUM_SECT), .BOOT_TOP(BOOT_TOP)) u_eval (
    .bits    (lock_bits),
    .guard_n (guard_n),
    .acc     (acc_q),
    .deny    (deny)
  );

  req_select #(.N(NUM_SECT), .W(SW)) u_sel (
    .deny  (deny),
    .valid (req_valid),
    .sect  (req_sect),
    .grant (req_grant)
  );

  assign bypass_active = acc_q;
  assign erase_skip    = erase_all ? deny  : '0;
  assign erase_take    = erase_all ? ~deny : '0;

  AST_BYPASS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    accel_lvl |=> bypass_active); // R6
  AST_BYPASS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !accel_lvl |=> !bypass_active); // R6
  AST_BYPASS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_active && req_valid && int'(req_sect) < NUM_SECT) |-> req_grant); // R7
  AST_GUARD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (!guard_n && !bypass_active && req_valid &&
     (int'(req_sect) == BOOT_LO || int'(req_sect) == BOOT_HI)) |-> !req_grant); // R4
  AST_MASK_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    erase_all |-> ((erase_skip & erase_take) == '0 &&
                   (erase_skip | erase_take) == '1)); // R8
  AST_MASK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !erase_all |-> (erase_skip == '0 && erase_take == '0)); // R8
  AST_RANGE_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(req_sect) >= NUM_SECT) |-> !req_grant); // R9
  AST_IDLE_NOGRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !req_grant); // R10
endmodule

// File: tb/tb_sector_guard.sv
module tb_sector_guard;
  localparam int N = 39;
  localparam int W = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, lock_we, lock_set, guard_n, accel_lvl, req_valid, erase_all;
  logic [W-1:0] lock_sect, req_sect;
  logic grant_b, grant_t, byp_b, byp_t;
  logic [N-1:0] skip_b, take_b, skip_t, take_t;

  sector_guard #(.BOOT_TOP(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .lock_we(lock_we), .lock_sect(lock_sect),
    .lock_set(lock_set), .guard_n(guard_n), .accel_lvl(accel_lvl),
    .req_valid(req_valid), .req_sect(req_sect), .erase_all(erase_all),
    .req_grant(grant_b), .bypass_active(byp_b),
    .erase_skip(skip_b), .erase_take(take_b));

  sector_guard #(.BOOT_TOP(1'b1)) dut_top (
    .clk(clk), .rst_n(rst_n), .lock_we(lock_we), .lock_sect(lock_sect),
    .lock_set(lock_set), .guard_n(guard_n), .accel_lvl(accel_lvl),
    .req_valid(req_valid), .req_sect(req_sect), .erase_all(erase_all),
    .req_grant(grant_t), .bypass_active(byp_t),
    .erase_skip(skip_t), .erase_take(take_t));

  int n_vec = 0;
  int n_bad = 0;
  bit mlock[N];
  bit macc;

  function automatic bit m_deny(int i, bit top);
    bit pair;
    pair = top ? (i >= N - 2) : (i < 2);
    return !macc && (mlock[i] || (!guard_n && pair));
  endfunction

  task automatic check_one(string tag, bit top, logic g, logic b,
                           logic [N-1:0] sk, logic [N-1:0] tk);
    logic e_g, e_b;
    logic [N-1:0] e_sk, e_tk;
    int rs;
    rs = int'(req_sect);
    e_b = macc;
    e_g = req_valid && (rs < N) && !m_deny(rs < N ? rs : 0, top);
    for (int i = 0; i < N; i++) begin
      e_sk[i] = erase_all &&  m_deny(i, top);
      e_tk[i] = erase_all && !m_deny(i, top);
    end
    n_vec++;
    if (g !== e_g || b !== e_b || sk !== e_sk || tk !== e_tk) begin
      n_bad++;
      $display("FAIL %s top=%0d: grant=%b byp=%b skip=%h take=%h, expected grant=%b byp=%b skip=%h take=%h",
               tag, top, g, b, sk, tk, e_g, e_b, e_sk, e_tk);
    end
  endtask

  task automatic step(string tag, bit r, bit we, int ls, bit lv, bit gn,
                      bit acc, bit rv, int rs, bit ea);
    @(negedge clk);
    rst_n = r; lock_we = we; lock_sect = W'(ls); lock_set = lv;
    guard_n = gn; accel_lvl = acc; req_valid = rv; req_sect = W'(rs);
    erase_all = ea;
    if (!r) begin
      foreach (mlock[i]) mlock[i] = 1'b0;
      macc = 1'b0;
    end
    #1;
    check_one(tag, 1'b0, grant_b, byp_b, skip_b, take_b);
    check_one(tag, 1'b1, grant_t, byp_t, skip_t, take_t);
    @(posedge clk);
    if (r) begin
      if (we && ls < N) mlock[ls] = lv;
      macc = acc;
    end
  endtask

  // Plain request helper: no lock write, given guard/accel levels.
  task automatic ask(string tag, bit gn, bit acc, int rs);
    step(tag, 1, 0, 0, 0, gn, acc, 1, rs, 0);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state, whole-array erase takes everything
    step("R1", 0, 0, 0, 0, 1, 0, 0, 0, 1);
    step("R1", 0, 0, 0, 0, 1, 0, 0, 0, 1);
    step("R1", 1, 0, 0, 0, 1, 0, 0, 0, 1);
    ask("R1", 1, 0, 0);
    ask("R1", 1, 0, 38);

    // R2: lock writes, including out-of-range indices
    step("R2", 1, 1, 5, 1, 1, 0, 0, 0, 1);
    step("R2", 1, 1, 20, 1, 1, 0, 0, 0, 1);
    step("R2", 1, 1, 0, 1, 1, 0, 0, 0, 1);
    step("R2", 1, 1, 38, 1, 1, 0, 0, 0, 1);
    step("R2", 1, 1, 20, 0, 1, 0, 0, 0, 1);
    step("R2", 1, 1, 45, 1, 1, 0, 0, 0, 1);
    step("R2", 1, 1, 39, 1, 1, 0, 0, 0, 1);
    step("R2", 1, 0, 0, 0, 1, 0, 0, 0, 1);

    // R3: locked versus free sectors
    ask("R3", 1, 0, 5);
    ask("R3", 1, 0, 6);
    ask("R3", 1, 0, 20);

    // R10: no request
    step("R10", 1, 0, 0, 0, 1, 0, 0, 5, 0);
    step("R10", 1, 0, 0, 0, 0, 0, 0, 6, 0);

    // R4: guard low on both boot ends and their neighbours
    ask("R4", 0, 0, 0);
    ask("R4", 0, 0, 1);
    ask("R4", 0, 0, 2);
    ask("R4", 0, 0, 36);
    ask("R4", 0, 0, 37);
    ask("R4", 0, 0, 38);

    // R5: guard high, boot pair follows stored bits
    ask("R5", 1, 0, 0);
    ask("R5", 1, 0, 1);
    ask("R5", 1, 0, 37);
    ask("R5", 1, 0, 38);
    step("R5", 1, 1, 0, 0, 1, 0, 1, 0, 0);
    ask("R5", 1, 0, 0);
    step("R5", 1, 1, 38, 0, 1, 0, 1, 38, 0);
    ask("R5", 1, 0, 38);
    step("R5", 1, 1, 0, 1, 1, 0, 0, 0, 0);
    step("R5", 1, 1, 38, 1, 1, 0, 0, 0, 0);

    // R6/R7: accelerate level edge, overlap with guard low
    ask("R6", 0, 1, 0);
    ask("R7", 0, 1, 0);
    ask("R7", 0, 1, 38);
    ask("R7", 0, 1, 5);
    step("R7", 1, 0, 0, 0, 0, 1, 0, 0, 1);
    step("R7", 1, 1, 7, 1, 0, 1, 1, 7, 0);
    ask("R7", 0, 1, 7);
    ask("R6", 0, 0, 7);
    ask("R7", 0, 0, 7);
    ask("R7", 0, 0, 1);

    // R8: whole-array erase masks under guard low and high
    step("R8", 1, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R8", 1, 0, 0, 0, 1, 0, 0, 0, 1);
    step("R8", 1, 0, 0, 0, 1, 0, 0, 0, 0);

    // R9: out-of-range requests, also during bypass
    ask("R9", 1, 0, 39);
    ask("R9", 1, 1, 50);
    ask("R9", 1, 1, 63);
    ask("R9", 1, 0, 39);

    // Mixed random traffic
    for (int k = 0; k < 600; k++) begin
      step("R3", 1, ($urandom % 3) == 0, int'($urandom % 48), $urandom % 2,
           ($urandom % 4) != 0, ($urandom % 5) == 0, $urandom % 2,
           int'($urandom % 64), ($urandom % 6) == 0);
    end

    // R1: reset mid-run restores defaults
    step("R1", 0, 0, 0, 0, 1, 1, 1, 5, 1);
    step("R1", 1, 0, 0, 0, 1, 0, 1, 5, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule